// File: doc/BRIEF.md
# Trigger-Committed Fractional Clock Divider

This block turns a free-running input clock into a stream of single-cycle enable pulses. The rate is set by a divisor held in a bit field of a 32-bit control word. The field is stored as the divisor minus one. Its low-order bits may be a fraction. When fraction bits are present, the implicit one is added to the integer part above them. Internally the divisor is kept as a scaled integer, left-shifted by the fraction width, and a phase accumulator alternates between the floor and ceiling periods. This gives the exact mean rate.

Software stages a new field value with an ordinary write. The value takes effect only when a write also sets the commit bit while the clock gate input is on. The commit bit then reads 1 until the divider has moved to the new divisor. The switch happens at the end of the current output period, so no period is cut short. The commit bit clears one cycle after the switch. Writes made while the commit bit reads 1 are discarded. A commit issued while the gate is off is dropped. When the block is the only divider on a clock path, it serves as the downstream stage.

Top module: `frac_clk_div`

## Requirements
- R1: With FRAC_W = 0, the field value f gives exactly one `tick_o` pulse every f+1 gated input cycles.
- R2: With FRAC_W > 0, the low FRAC_W bits of the field are the fraction and the scaled divisor is D = f + 2^FRAC_W. Counting from a divisor switch (or from reset), the first N gated cycles produce exactly floor(N·2^FRAC_W / D) pulses.
- R3: A write with `wr_data[TRIG_BIT]` = 1 while `gate_en` = 1 and the block is idle makes `rd_data[TRIG_BIT]` read 1 from the next cycle.
- R4: A committed divisor is applied on the cycle that ends the current period. That period keeps its old length, and the next period starts from zero phase with the new divisor.
- R5: `rd_data[TRIG_BIT]` returns to 0 exactly one cycle after the pulse at which the new divisor was applied.
- R6: A commit write made while `gate_en` = 0 leaves the commit bit at 0 and leaves the active divisor unchanged.
- R7: While the commit bit reads 1, writes change neither the staged field nor the commit state.
- R8: While `gate_en` = 0, no pulse is produced and the phase is held.
- R9: Reset is synchronous and active low. It loads the field with RESET_FIELD as both staged and active value, clears the commit bit and holds `tick_o` at 0.
- R10: `rd_data` returns the staged field at bits [FIELD_LSB +: FIELD_W] and the commit bit at TRIG_BIT. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_en | input | 1 | Clock gate state; divider runs and commits are accepted only when 1 |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Control word: divisor field and commit bit |
| rd_data | output | REG_W | Read-back of the staged field and the commit (busy) bit |
| tick_o | output | 1 | Single-cycle output pulse, one per divided period |

## Verification
The bench builds two copies that share all inputs. One has an 8-bit field with two fraction bits, so the fractional dithering and a full-range field of 255 are covered. The other has no fraction bits, so the same writes show pure integer division. The integer copy has exact, fixed periods, which lets the bench measure single period lengths around a commit: the old period is not shortened and the first new period is correct. Each copy reaches its switch at a different cycle, so each copy's pulse count is started from the clearing of its own commit bit.

// File: rtl/fdiv_pkg.sv
// Package: shared types for the fractional divider.
// Assumes: nothing beyond IEEE 1800-2017.
package fdiv_pkg;
    // Commit handshake states: idle, waiting for a period boundary, settling.
    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_PEND   = 2'd1,
        CM_SETTLE = 2'd2
    } commit_t;
endpackage

// File: rtl/fdiv_regif.sv
// Module: fdiv_regif
// Holds the staged divisor field and runs the commit handshake.
// A write in idle stages the field. If the commit bit is set and the gate is
// on, the write also arms a commit. The armed commit is applied at the next
// period boundary reported by the phase engine, then one settle cycle follows.
// Assumes: boundary is a single-cycle indication from the phase engine.
module fdiv_regif
    import fdiv_pkg::*;
#(
    parameter int FIELD_W     = 8,
    parameter int RESET_FIELD = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_en,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic               wr_commit,
    input  logic               boundary,
    output logic [FIELD_W-1:0] staged,
    output logic               apply,
    output logic               busy
);
    commit_t state;

    // Decode the handshake outputs from the state.
    always_comb begin
        apply = (state == CM_PEND) && boundary;
        busy  = (state != CM_IDLE);
    end

    // Stage writes and advance the commit handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CM_IDLE;
            staged <= FIELD_W'(RESET_FIELD);
        end else begin
            case (state)
                CM_IDLE: begin
                    if (wr_en) begin
                        staged <= wr_field;
                        if (wr_commit && gate_en) begin
                            state <= CM_PEND;
                        end
                    end
                end
                CM_PEND: begin
                    if (boundary) begin
                        state <= CM_SETTLE;
                    end
                end
                default: begin
                    state <= CM_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/fdiv_phase.sv
// Module: fdiv_phase
// Phase accumulator for the divider. Each gated cycle adds 2^FRAC_W to the
// phase. When the sum reaches the scaled divisor, a period ends and the
// divisor is subtracted. This alternates between floor and ceiling periods.
// A load replaces the divisor and restarts the phase from zero.
// Assumes: load is asserted only together with hit; FRAC_W < FIELD_W.
module fdiv_phase #(
    parameter int FIELD_W     = 8,
    parameter int FRAC_W      = 2,
    parameter int RESET_FIELD = 3,
    localparam int D_W        = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               load,
    input  logic [FIELD_W-1:0] new_field,
    output logic               hit,
    output logic               tick,
    output logic [D_W-1:0]     div_act
);
    localparam logic [D_W-1:0] STEP    = D_W'(1) << FRAC_W;
    localparam logic [D_W-1:0] RST_DIV = D_W'(RESET_FIELD) + STEP;

    logic [D_W-1:0] acc;
    logic [D_W:0]   sum;
    logic [D_W:0]   rem;
    logic [D_W-1:0] new_div;

    // Form the next phase and detect the end of a period.
    always_comb begin
        sum     = {1'b0, acc} + {1'b0, STEP};
        rem     = sum - {1'b0, div_act};
        hit     = run && (sum >= {1'b0, div_act});
        new_div = {1'b0, new_field} + STEP;
    end

    // Advance the phase, register the pulse and swap the divisor on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            tick    <= 1'b0;
            div_act <= RST_DIV;
        end else begin
            tick <= hit;
            if (load) begin
                div_act <= new_div;
                acc     <= '0;
            end else if (hit) begin
                acc <= rem[D_W-1:0];
            end else if (run) begin
                acc <= sum[D_W-1:0];
            end
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
// Module: frac_clk_div (top)
// Divider with a register-mapped divisor field stored as divisor minus one,
// optional fraction bits and a self-clearing commit bit.
// Assumes: FIELD_LSB + FIELD_W <= REG_W, TRIG_BIT lies outside the field,
// FRAC_W < FIELD_W.
module frac_clk_div #(
    parameter int REG_W       = 32,
    parameter int FIELD_LSB   = 4,
    parameter int FIELD_W     = 8,
    parameter int FRAC_W      = 2,
    parameter int TRIG_BIT    = 31,
    parameter int RESET_FIELD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             tick_o
);
    localparam int D_W = FIELD_W + 1;

    logic [FIELD_W-1:0] staged;
    logic               apply;
    logic               busy;
    logic               hit;
    logic [D_W-1:0]     div_act;
    logic               wr_data_unused;

    // Only the field and commit bit of the write word are decoded.
    assign wr_data_unused = ^wr_data;

    fdiv_regif #(
        .FIELD_W    (FIELD_W),
        .RESET_FIELD(RESET_FIELD)
    ) regif_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_en  (gate_en),
        .wr_en    (wr_en),
        .wr_field (wr_data[FIELD_LSB +: FIELD_W]),
        .wr_commit(wr_data[TRIG_BIT]),
        .boundary (hit),
        .staged   (staged),
        .apply    (apply),
        .busy     (busy)
    );

    fdiv_phase #(
        .FIELD_W    (FIELD_W),
        .FRAC_W     (FRAC_W),
        .RESET_FIELD(RESET_FIELD)
    ) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gate_en),
        .load     (apply),
        .new_field(staged),
        .hit      (hit),
        .tick     (tick_o),
        .div_act  (div_act)
    );

    // Assemble the read-back word.
    always_comb begin
        rd_data                        = '0;
        rd_data[FIELD_LSB +: FIELD_W]  = staged;
        rd_data[TRIG_BIT]              = busy;
    end
endmodule

// File: rtl/frac_clk_div_chk.sv
// Module: frac_clk_div_chk
// Temporal checks on the divider, bound into every frac_clk_div instance.
// Assumes: connected through the bind below.
module frac_clk_div_chk #(
    parameter int FIELD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gate_en,
    input logic               wr_en,
    input logic               wr_commit,
    input logic               busy,
    input logic [FIELD_W-1:0] field_rd,
    input logic               tick_o,
    input logic [FIELD_W:0]   div_act
);
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_commit && gate_en));

    // R6
    gated_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_commit && !gate_en && !busy) |=> !busy);

    // R7
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(field_rd));

    // R8
    gate_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(gate_en));

    // R4
    switch_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> tick_o);

    // R5
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick_o));
endmodule

bind frac_clk_div frac_clk_div_chk #(
    .FIELD_W(FIELD_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_en  (gate_en),
    .wr_en    (wr_en),
    .wr_commit(wr_data[TRIG_BIT]),
    .busy     (rd_data[TRIG_BIT]),
    .field_rd (rd_data[FIELD_LSB +: FIELD_W]),
    .tick_o   (tick_o),
    .div_act  (div_act)
);

// File: tb/frac_clk_div_tb_top.sv
// Bench: two dividers (two fraction bits, and integer only) on shared inputs.
module frac_clk_div_tb_top;
    localparam int W    = 200;
    localparam int NV   = 6;
    localparam int TRIG = 31;
    localparam int LSB  = 4;
    // Field values and expected pulse counts over W cycles (frac, integer).
    localparam int VEC_FIELD [NV] = '{0, 1, 5, 6, 10, 255};
    localparam int VEC_FRAC  [NV] = '{200, 160, 88, 80, 57, 3};
    localparam int VEC_INT   [NV] = '{200, 100, 33, 28, 18, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_f, rd_i;
    logic        tick_f, tick_i;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int          cyc = 0;
    int          last_t = 0;
    int          prev_t = 0;

    always #5 clk = ~clk;

    frac_clk_div #(.FRAC_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_f), .tick_o(tick_f));

    frac_clk_div #(.FRAC_W(0)) dut_int_i (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_i), .tick_o(tick_i));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        end
    endtask

    // Drive one write at a falling edge; returns one falling edge later.
    task automatic write_word(input int field, input bit commit);
        wr_data = '0;
        wr_data[LSB +: 8] = 8'(field);
        wr_data[TRIG] = commit;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cyc++;
    endtask

    // Count pulses of each copy over W cycles from the clearing of its busy bit.
    task automatic measure(output int cf, output int ci);
        bit sf = 0, si = 0;
        int nf = 0, ni = 0;
        cf = 0; ci = 0;
        while (nf < W || ni < W) begin
            @(negedge clk);
            cyc++;
            if (!sf && !rd_f[TRIG]) sf = 1;
            if (!si && !rd_i[TRIG]) si = 1;
            if (sf && nf < W) begin nf++; cf += int'(tick_f); end
            if (si && ni < W) begin ni++; ci += int'(tick_i); end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int cf, ci, t1, t2, t3, n, ticks;
        bit cleared;
        // R9 reset state
        repeat (3) @(negedge clk);
        check(rd_f[LSB +: 8] == 8'd3, "R9 reset field", int'(rd_f[LSB +: 8]), 3);
        check(rd_f[TRIG] == 1'b0, "R9 reset busy", int'(rd_f[TRIG]), 0);
        check(tick_f == 1'b0 && tick_i == 1'b0, "R9 reset tick", int'(tick_f), 0);
        rst_n = 1'b1;
        measure(cf, ci);
        check(cf == 114, "R2 reset divisor frac", cf, 114);
        check(ci == 50, "R1 reset divisor int", ci, 50);

        // Vector table: commit each field, then count pulses.
        for (int i = 0; i < NV; i++) begin
            write_word(VEC_FIELD[i], 1'b1);
            check(rd_f[TRIG] == 1'b1, "R3 busy after commit", int'(rd_f[TRIG]), 1);
            measure(cf, ci);
            check(cf == VEC_FRAC[i], "R2 frac count", cf, VEC_FRAC[i]);
            check(ci == VEC_INT[i], "R1 int count", ci, VEC_INT[i]);
        end
        check(rd_f == (32'd255 << LSB), "R10 read-back word", int'(rd_f), 255 << LSB);

        // Set a known divisor: int copy period 10.
        write_word(9, 1'b1);
        measure(cf, ci);

        // R8: gate off, no pulses.
        gate_en = 1'b0;
        ticks = 0;
        repeat (30) begin
            @(negedge clk); cyc++;
            ticks += int'(tick_f) + int'(tick_i);
        end
        check(ticks == 0, "R8 no pulse while gated", ticks, 0);

        // R6: commit while gated is dropped.
        write_word(2, 1'b1);
        check(rd_f[TRIG] == 1'b0 && rd_i[TRIG] == 1'b0, "R6 busy stays clear",
              int'(rd_f[TRIG]), 0);
        check(rd_f[LSB +: 8] == 8'd2, "R10 staged field read-back", int'(rd_f[LSB +: 8]), 2);
        gate_en = 1'b1;
        n = 0; t1 = 0; t2 = 0; t3 = 0;
        while (n < 3) begin
            @(negedge clk); cyc++;
            if (tick_i) begin
                n++;
                t1 = t2; t2 = t3; t3 = cyc;
            end
        end
        check(t3 - t2 == 10 && t2 - t1 == 10, "R6 divisor unchanged", t3 - t2, 10);

        // R4 / R5: commit period 3 on the int copy, measure around the switch.
        prev_t = t2; last_t = t3;
        wr_data = '0; wr_data[LSB +: 8] = 8'd2; wr_data[TRIG] = 1'b1; wr_en = 1'b1;
        cleared = 0;
        n = 0;
        while (n < 1) begin
            @(negedge clk); cyc++;
            wr_en = 1'b0;
            if (tick_i) begin prev_t = last_t; last_t = cyc; if (cleared) n++; end
            if (!cleared && !rd_i[TRIG] && cyc > t3 + 1) begin
                cleared = 1;
                check(last_t == cyc - 1, "R5 busy clears one cycle after switch",
                      cyc - last_t, 1);
                check(last_t - prev_t == 10, "R4 old period not shortened",
                      last_t - prev_t, 10);
            end
        end
        check(last_t - prev_t == 3, "R4 first new period", last_t - prev_t, 3);

        // R7: writes while busy are discarded.
        write_word(40, 1'b1);
        gate_en = 1'b0;
        write_word(100, 1'b0);
        check(rd_f[LSB +: 8] == 8'd40, "R7 staged field held", int'(rd_f[LSB +: 8]), 40);
        check(rd_f[TRIG] == 1'b1, "R7 busy held", int'(rd_f[TRIG]), 1);
        gate_en = 1'b1;
        measure(cf, ci);
        check(cf == 18, "R7 first value applied frac", cf, 18);
        check(ci == 4, "R7 first value applied int", ci, 4);

        summary();
        $finish;
    end
endmodule